// File: doc/BRIEF.md
# Dual-Port Memory with Per-Port Aspect Ratios

This block holds 18,432 bits behind two access ports. Each port sees the same storage through its own word shape. A parameter per port picks one of six shapes. Three are data-only: 16K x 1, 8K x 2 and 4K x 4. Three carry parity bits: 2K x 9, 1K x 18 and 512 x 36. A narrow port sees the wide words split into little-endian lanes, so data written through one port can be read back through the other at a different width. The parity bits can only be reached from the 9-, 18- and 36-bit shapes.

Both ports can read and write in the same cycle. Reads and writes are synchronous, and every access is accepted in its cycle. There is no valid/ready handshake because the memory never stalls: a port that asserts its enable is served on the next edge, with no back-pressure. For single-port use, tie port B's enable low. The array has no reset, and reset clears only the two output registers.

Top module: `tdp_ram18`

## Requirements
- R1: Parameter MODE (0..5) per port selects a data width of 2^MODE bits and a depth of 16384 >> MODE words. Modes 3, 4 and 5 add 1, 2 and 4 parity bits. The highest valid address is (16384 >> MODE) - 1.
- R2: A read or write uses the inputs present at a rising clock edge when the enable is high. Read data appears on the data and parity outputs after that same edge.
- R3: When a port writes, its outputs show the contents the addressed location held before that write (read-first). The new contents are visible from the next read.
- R4: While a port's enable is low, its outputs hold their value, and its write enable has no effect on the array.
- R5: Narrow address n of a port in mode m selects data bits [(n mod 2^(5-m)) * 2^m +: 2^m] of 36-bit word n >> (5-m), where bits 31:0 are data. For parity modes, it also selects parity bits [(n mod 2^(5-m)) * 2^(m-3) +: 2^(m-3)] of word bits 35:32.
- R6: Data written through one port is read back through the other port with the mapping of R5, whatever the two modes are.
- R7: In modes 0 to 2, parity inputs are ignored and parity outputs read zero. A write from such a port leaves the parity bits of the word unchanged.
- R8: The two ports can each read or write in the same cycle. Writes to different bits are all kept. A port that reads a location while the other port writes it sees the old contents.
- R9: Both ports writing overlapping bits in the same cycle is a forbidden use, and the stored value is then undefined.
- R10: Reset, active low and synchronous, clears both ports' data and parity outputs to zero and leaves the array contents intact.
- R11: Address bits above the mode's address width and data or parity input bits above the mode's width are ignored. Output bits above the mode's width read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable, qualified by en_a |
| addr_a | input | 14 | Port A address, low 14-MODE_A bits used |
| din_a | input | 32 | Port A write data, low 2^MODE_A bits used |
| pin_a | input | 4 | Port A write parity, used in modes 3 to 5 |
| dout_a | output | 32 | Port A read data |
| pout_a | output | 4 | Port A read parity |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable, qualified by en_b |
| addr_b | input | 14 | Port B address, low 14-MODE_B bits used |
| din_b | input | 32 | Port B write data, low 2^MODE_B bits used |
| pin_b | input | 4 | Port B write parity, used in modes 3 to 5 |
| dout_b | output | 32 | Port B read data |
| pout_b | output | 4 | Port B read parity |

## Verification
The hardest case to reach from the ports is the same 36-bit word being touched by both ports in one cycle: one port writes it while the other reads it, or the two write different words at once. The stimulus arranges this by pre-loading known words through the wide port. It then issues the wide write and the narrow read in the same cycle, and reads the word back to show both the old value that was seen and the new value that was stored. Parity preservation is reached in a similar way. A wide write sets parity, a narrow write changes one lane, and a wide read then shows the parity still intact.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  localparam int DATA_W  = 32;
  localparam int PAR_W   = 4;
  localparam int WORD_W  = DATA_W + PAR_W;
  localparam int WORDS   = 512;
  localparam int WIDX_W  = $clog2(WORDS);
  localparam int ADDR_W  = 14;
  localparam int LANE_W  = 5;
  localparam int TOP_MODE = 5;

  function automatic int data_w(int m);
    return 1 << m;
  endfunction

  function automatic int par_w(int m);
    return (m >= 3) ? (1 << (m - 3)) : 0;
  endfunction

  function automatic logic [DATA_W-1:0] dmask(int m);
    return DATA_W'((64'd1 << data_w(m)) - 64'd1);
  endfunction

  function automatic logic [PAR_W-1:0] pmask(int m);
    return PAR_W'((8'd1 << par_w(m)) - 8'd1);
  endfunction
endpackage

// File: rtl/tdp_addr_map.sv
module tdp_addr_map
  import tdp_pkg::*;
#(
  parameter int MODE = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [PAR_W-1:0]  pin,
  output logic [WIDX_W-1:0] widx,
  output logic [LANE_W-1:0] lane,
  output logic [WORD_W-1:0] bmask,
  output logic [WORD_W-1:0] bdata
);
  localparam int W  = data_w(MODE);
  localparam int PW = par_w(MODE);
  localparam int LW = TOP_MODE - MODE;
  localparam logic [DATA_W-1:0] DM = dmask(MODE);
  localparam logic [PAR_W-1:0]  PM = pmask(MODE);
  localparam logic [LANE_W-1:0] LMASK = LANE_W'((1 << LW) - 1);

  always_comb begin
    widx  = WIDX_W'(addr >> LW);
    lane  = addr[LANE_W-1:0] & LMASK;
    bmask = {PM << (lane * PW), DM << (lane * W)};
    bdata = {(pin & PM) << (lane * PW), (din & DM) << (lane * W)};
  end
endmodule

// File: rtl/tdp_lane_pick.sv
module tdp_lane_pick
  import tdp_pkg::*;
#(
  parameter int MODE = 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  output logic [DATA_W-1:0] dout,
  output logic [PAR_W-1:0]  pout
);
  localparam int W  = data_w(MODE);
  localparam int PW = par_w(MODE);
  localparam logic [DATA_W-1:0] DM = dmask(MODE);
  localparam logic [PAR_W-1:0]  PM = pmask(MODE);

  always_comb begin
    dout = (word[DATA_W-1:0] >> (lane * W)) & DM;
    pout = (word[WORD_W-1:DATA_W] >> (lane * PW)) & PM;
  end
endmodule

// File: rtl/tdp_ram18.sv
module tdp_ram18
  import tdp_pkg::*;
#(
  parameter int MODE_A = 5,
  parameter int MODE_B = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_a,
  input  logic        we_a,
  input  logic [13:0] addr_a,
  input  logic [31:0] din_a,
  input  logic [3:0]  pin_a,
  output logic [31:0] dout_a,
  output logic [3:0]  pout_a,
  input  logic        en_b,
  input  logic        we_b,
  input  logic [13:0] addr_b,
  input  logic [31:0] din_b,
  input  logic [3:0]  pin_b,
  output logic [31:0] dout_b,
  output logic [3:0]  pout_b
);
  logic [WORD_W-1:0] mem [WORDS];

  logic [WIDX_W-1:0] widx_a, widx_b;
  logic [LANE_W-1:0] lane_a, lane_b;
  logic [WORD_W-1:0] bm_a, bd_a, bm_b, bd_b;
  logic [WORD_W-1:0] merged_a, base_b, merged_b;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic [PAR_W-1:0]  rp_a, rp_b;
  logic              wr_a, wr_b;

  tdp_addr_map #(.MODE(MODE_A)) u_map_a (
    .addr(addr_a), .din(din_a), .pin(pin_a),
    .widx(widx_a), .lane(lane_a), .bmask(bm_a), .bdata(bd_a));

  tdp_addr_map #(.MODE(MODE_B)) u_map_b (
    .addr(addr_b), .din(din_b), .pin(pin_b),
    .widx(widx_b), .lane(lane_b), .bmask(bm_b), .bdata(bd_b));

  assign wr_a = en_a && we_a;
  assign wr_b = en_b && we_b;

  // Port B merges on top of port A's result when both hit one word,
  // so writes to disjoint lanes of that word are both kept.
  always_comb begin
    merged_a = (mem[widx_a] & ~bm_a) | bd_a;
    base_b   = (wr_a && (widx_a == widx_b)) ? merged_a : mem[widx_b];
    merged_b = (base_b & ~bm_b) | bd_b;
  end

  always_ff @(posedge clk) begin
    if (wr_a) mem[widx_a] <= merged_a;
    if (wr_b) mem[widx_b] <= merged_b;
  end

  tdp_lane_pick #(.MODE(MODE_A)) u_pick_a (
    .word(mem[widx_a]), .lane(lane_a), .dout(rd_a), .pout(rp_a));

  tdp_lane_pick #(.MODE(MODE_B)) u_pick_b (
    .word(mem[widx_b]), .lane(lane_b), .dout(rd_b), .pout(rp_b));

  // Output registers capture pre-write contents: read-first on both ports.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_a <= '0;
      pout_a <= '0;
      dout_b <= '0;
      pout_b <= '0;
    end else begin
      if (en_a) begin
        dout_a <= rd_a;
        pout_a <= rp_a;
      end
      if (en_b) begin
        dout_b <= rd_b;
        pout_b <= rp_b;
      end
    end
  end
endmodule

// File: rtl/tdp_ram18_chk.sv
module tdp_ram18_chk
  import tdp_pkg::*;
#(
  parameter int MODE_A = 5,
  parameter int MODE_B = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en_a,
  input logic        we_a,
  input logic [13:0] addr_a,
  input logic [31:0] din_a,
  input logic [3:0]  pin_a,
  input logic [31:0] dout_a,
  input logic [3:0]  pout_a,
  input logic        en_b,
  input logic        we_b,
  input logic [13:0] addr_b,
  input logic [31:0] din_b,
  input logic [3:0]  pin_b,
  input logic [31:0] dout_b,
  input logic [3:0]  pout_b
);
  localparam int LWA = TOP_MODE - MODE_A;
  localparam int LWB = TOP_MODE - MODE_B;
  localparam logic [31:0] DMA = dmask(MODE_A);
  localparam logic [31:0] DMB = dmask(MODE_B);
  localparam logic [3:0]  PMA = pmask(MODE_A);
  localparam logic [3:0]  PMB = pmask(MODE_B);

  logic [WIDX_W-1:0] wia, wib;
  int lo_a, hi_a, lo_b, hi_b;
  logic clash;

  always_comb begin
    wia  = WIDX_W'(addr_a >> LWA);
    wib  = WIDX_W'(addr_b >> LWB);
    lo_a = (int'(addr_a) % (1 << LWA)) * data_w(MODE_A);
    hi_a = lo_a + data_w(MODE_A);
    lo_b = (int'(addr_b) % (1 << LWB)) * data_w(MODE_B);
    hi_b = lo_b + data_w(MODE_B);
    clash = en_a && we_a && en_b && we_b && (wia == wib) &&
            (lo_a < hi_b) && (lo_b < hi_a);
  end

  // R9: overlapping same-cycle writes are a forbidden use
  p_no_collide_r9: assert property (@(posedge clk) disable iff (!rst_n) !clash);

  // R4: disabled port holds its outputs
  p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |=> $stable(dout_a) && $stable(pout_a));
  p_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b |=> $stable(dout_b) && $stable(pout_b));

  // R11: output bits beyond the mode width stay zero
  p_width_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_a & ~DMA) == '0);
  p_width_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_b & ~DMB) == '0);

  // R7: no parity visible from data-only modes
  p_par_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_a & ~PMA) == '0);
  p_par_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_b & ~PMB) == '0);

  // R2: a write followed by a read of the same address returns the written value
  p_readback_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && !we_a && $past(en_a && we_a) && addr_a == $past(addr_a) &&
     !$past(en_b && we_b))
    |=> ((dout_a & DMA) == ($past(din_a, 2) & DMA)) &&
        ((pout_a & PMA) == ($past(pin_a, 2) & PMA)));
  p_readback_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_b && !we_b && $past(en_b && we_b) && addr_b == $past(addr_b) &&
     !$past(en_a && we_a))
    |=> ((dout_b & DMB) == ($past(din_b, 2) & DMB)) &&
        ((pout_b & PMB) == ($past(pin_b, 2) & PMB)));
endmodule

bind tdp_ram18 tdp_ram18_chk #(.MODE_A(MODE_A), .MODE_B(MODE_B)) u_chk (.*);

// File: tb/tdp_ram18_tb.sv
module tdp_ram18_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_a = 1'b0, we_a = 1'b0, en_b = 1'b0, we_b = 1'b0;
  logic [13:0] addr_a = '0, addr_b = '0;
  logic [31:0] din_a = '0, din_b = '0;
  logic [3:0]  pin_a = '0, pin_b = '0;
  logic [31:0] dout_a, dout_b;
  logic [3:0]  pout_a, pout_b;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tdp_ram18 #(.MODE_A(5), .MODE_B(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a), .pin_a(pin_a),
    .dout_a(dout_a), .pout_a(pout_a),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b), .pin_b(pin_b),
    .dout_b(dout_b), .pout_b(pout_b));

  // Vector: {portB, we, addr[13:0], data[31:0], par[3:0], exp[31:0], expp[3:0]}
  // Port A is 512 x 36 (mode 5), port B is 4K x 4 (mode 2, lane = addr mod 8).
  localparam int NV = 12;
  localparam logic [87:0] VEC [NV] = '{
    {1'b0, 1'b1, 14'd0,    32'h89ABCDEF, 4'hA, 32'h0,        4'h0},
    {1'b1, 1'b0, 14'd0,    32'h0,        4'h0, 32'h0000000F, 4'h0},
    {1'b1, 1'b0, 14'd7,    32'h0,        4'h0, 32'h00000008, 4'h0},
    {1'b1, 1'b0, 14'd3,    32'h0,        4'h0, 32'h0000000C, 4'h0},
    {1'b1, 1'b1, 14'd5,    32'h1,        4'h0, 32'h0,        4'h0},
    {1'b0, 1'b0, 14'd0,    32'h0,        4'h0, 32'h891BCDEF, 4'hA},
    {1'b0, 1'b1, 14'd511,  32'h12345678, 4'h5, 32'h0,        4'h0},
    {1'b1, 1'b0, 14'd4095, 32'h0,        4'h0, 32'h00000001, 4'h0},
    {1'b1, 1'b0, 14'd4088, 32'h0,        4'h0, 32'h00000008, 4'h0},
    {1'b1, 1'b1, 14'd4089, 32'hF,        4'h0, 32'h0,        4'h0},
    {1'b0, 1'b0, 14'd511,  32'h0,        4'h0, 32'h123456F8, 4'h5},
    {1'b1, 1'b0, 14'd4089, 32'h0,        4'h0, 32'h0000000F, 4'h0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a negedge; applies inputs for one rising edge and returns at the next negedge.
  task automatic step(input logic ea, wa, input logic [13:0] aa, input logic [31:0] da,
                      input logic [3:0] pa, input logic eb, wb, input logic [13:0] ab,
                      input logic [31:0] db, input logic [3:0] pb);
    en_a = ea; we_a = wa; addr_a = aa; din_a = da; pin_a = pa;
    en_b = eb; we_b = wb; addr_b = ab; din_b = db; pin_b = pb;
    @(negedge clk);
    en_a = 1'b0; we_a = 1'b0; en_b = 1'b0; we_b = 1'b0;
  endtask

  task automatic op_a(input logic wa, input logic [13:0] aa, input logic [31:0] da, input logic [3:0] pa);
    step(1'b1, wa, aa, da, pa, 1'b0, 1'b0, 14'd0, 32'd0, 4'd0);
  endtask

  task automatic op_b(input logic wb, input logic [13:0] ab, input logic [31:0] db, input logic [3:0] pb);
    step(1'b0, 1'b0, 14'd0, 32'd0, 4'd0, 1'b1, wb, ab, db, pb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: outputs are zero out of reset
    chk("R10 reset dout_a", dout_a, 32'h0);
    chk("R10 reset dout_b", dout_b, 32'h0);
    chk("R10 reset pout_a", {28'h0, pout_a}, 32'h0);

    // R1 R5 R6 R7: table walk across both widths, including top addresses
    for (int i = 0; i < NV; i++) begin
      logic [87:0] v;
      v = VEC[i];
      if (v[87]) op_b(v[86], v[85:72], v[71:40], v[39:36]);
      else       op_a(v[86], v[85:72], v[71:40], v[39:36]);
      if (!v[86]) begin
        if (v[87]) begin
          chk("R1 R5 R6 table dout_b", dout_b, v[35:4]);
          chk("R7 table pout_b", {28'h0, pout_b}, {28'h0, v[3:0]});
        end else begin
          chk("R1 R5 R6 table dout_a", dout_a, v[35:4]);
          chk("R7 table pout_a", {28'h0, pout_a}, {28'h0, v[3:0]});
        end
      end
    end

    // R3: read-first on the writing port
    op_a(1'b1, 14'd30, 32'h11111111, 4'h1);
    op_a(1'b1, 14'd30, 32'h22222222, 4'h2);
    chk("R3 old data on write", dout_a, 32'h11111111);
    chk("R3 old parity on write", {28'h0, pout_a}, 32'h1);
    op_a(1'b0, 14'd30, 32'h0, 4'h0);
    chk("R3 new data next read", dout_a, 32'h22222222);

    // R8: port B reads word 31 lane 0 while port A rewrites it
    op_a(1'b1, 14'd31, 32'h0000000C, 4'h0);
    step(1'b1, 1'b1, 14'd31, 32'h33333333, 4'h0, 1'b1, 1'b0, 14'd248, 32'h0, 4'h0);
    chk("R8 cross-port read sees old", dout_b, 32'hC);
    op_b(1'b0, 14'd248, 32'h0, 4'h0);
    chk("R8 cross-port new value", dout_b, 32'h3);

    // R8: simultaneous writes to different words (no overlap, R9 avoided)
    op_a(1'b1, 14'd60, 32'h0, 4'h0);
    step(1'b1, 1'b1, 14'd50, 32'hCAFEF00D, 4'h3, 1'b1, 1'b1, 14'd484, 32'h6, 4'h0);
    op_a(1'b0, 14'd50, 32'h0, 4'h0);
    chk("R8 port A write kept", dout_a, 32'hCAFEF00D);
    op_a(1'b0, 14'd60, 32'h0, 4'h0);
    chk("R8 port B write kept", dout_a, 32'h00060000);

    // R4: disabled port holds output and ignores write enable
    op_a(1'b0, 14'd0, 32'h0, 4'h0);
    step(1'b0, 1'b0, 14'd511, 32'h0, 4'h0, 1'b0, 1'b0, 14'd0, 32'h0, 4'h0);
    chk("R4 hold while disabled", dout_a, 32'h891BCDEF);
    step(1'b0, 1'b1, 14'd0, 32'h0, 4'h0, 1'b0, 1'b0, 14'd0, 32'h0, 4'h0);
    op_a(1'b0, 14'd0, 32'h0, 4'h0);
    chk("R4 write without enable ignored", dout_a, 32'h891BCDEF);

    // R11: upper address and data bits ignored; R7 narrow parity input ignored
    op_a(1'b1, 14'h3E03, 32'hDEADBEEF, 4'hF);
    op_a(1'b0, 14'd3, 32'h0, 4'h0);
    chk("R11 upper address bits ignored", dout_a, 32'hDEADBEEF);
    op_b(1'b1, 14'd24, 32'hFFFFFFF9, 4'hF);
    op_b(1'b0, 14'h3018, 32'h0, 4'h0);
    chk("R11 narrow upper data ignored", dout_b, 32'h9);
    chk("R7 narrow pout zero", {28'h0, pout_b}, 32'h0);
    op_a(1'b0, 14'd3, 32'h0, 4'h0);
    chk("R6 narrow write merged", dout_a, 32'hDEADBEE9);
    chk("R7 parity kept after narrow write", {28'h0, pout_a}, 32'hF);

    // R10: reset clears outputs but not the array
    op_a(1'b0, 14'd3, 32'h0, 4'h0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears dout_a", dout_a, 32'h0);
    rst_n = 1'b1;
    op_a(1'b0, 14'd3, 32'h0, 4'h0);
    chk("R10 array kept through reset", dout_a, 32'hDEADBEE9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule